// File: doc/BRIEF.md
# Controlling-Value Operand-Gated Output Stage

This block is a registered datapath stage whose result comes from one multi-input gate: AND, NAND, OR or NOR, picked at build time. One gate input, the early bit, comes from a narrow logic cone. That cone sees its operands one cycle before the wide operand bus, and its one-bit result is kept in a register. The other gate inputs come from a wide operand register, one bit per field of that register.

When the stored early bit equals the gate's controlling value, that bit alone decides the result. The wide operand register is then left unloaded, so no new data reaches the wide reduction logic and it does not switch. The output is the same in every cycle as that of a stage that loads the wide register on every valid beat. A counter reports how many valid beats were served without a load.

In use, a producer sends the cone operands for item n in the same cycle as the wide operands for item n-1. It then sends the wide operands for item n one cycle later. The result for item n appears on the cycle after its wide operands.

Top module: `operand_gate_stage`

## Requirements
- R1: After a synchronous active-high reset, `resValid` is 0 and `holdCount` is 0. The stored early bit is set to the non-controlling value, so a wide beat that arrives before any cone beat loads the operand register and is not counted as held.
- R2: The early bit is the XOR of all bits of `coneIn`. It is captured at the clock edge of a cycle with `coneValid` = 1 and is used by the next wide beat.
- R3: For a wide beat (`opValid` = 1) in cycle n, `resValid` is 1 in cycle n+1. Field k is bits [k*FIELD_W +: FIELD_W] of `opIn`. Each field is reduced to its XOR. In cycle n+1, `resOut` equals G(early bit, field bits), where G is AND for GATE_SEL=0, NAND for 1, OR for 2 and NOR for 3.
- R4: When the early bit used by a beat equals the controlling value, `resOut` takes the forced level regardless of `opIn`. The controlling value is 0 for AND and NAND and 1 for OR and NOR. The forced level is 0 for AND and NOR and 1 for NAND and OR.
- R5: A beat whose early bit is the controlling value leaves the operand register unloaded. `holdCount` rises by one at that beat's edge.
- R6: `holdCount` saturates at its all-ones value.
- R7: Cycles with `coneValid` = 0 keep the stored early bit. Several wide beats in a row then reuse the same early bit.
- R8: A cycle with `opValid` = 0 leaves `resValid` at 0 in the next cycle. `resOut` and `holdCount` stay unchanged.
- R9: Over a random stream with an AND gate, roughly half of the beats are served without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coneValid | input | 1 | Cone operands present this cycle |
| coneIn | input | CONE_W | Operands of the early cone |
| opValid | input | 1 | Wide operand beat present this cycle |
| opIn | input | NUM_FIELDS*FIELD_W | Wide operand bus |
| resOut | output | 1 | Gate result |
| resValid | output | 1 | Result belongs to the beat of the previous cycle |
| holdCount | output | CNT_W | Count of beats served without loading the operand register |

## Verification
One stimulus stream drives four copies of the stage, one for each gate type. The same early bit is controlling for two of the copies and non-controlling for the other two. This separates a forced result from one that is computed from the fields. Directed beats pair a non-controlling early bit with fields of mixed parity, so that every field reaches the result. A run of beats with no new cone operands confirms that the early bit is reused. Idle cycles confirm that the outputs stay frozen. A random stream with random gaps then checks each result against a stage that loads on every beat. A fifth copy with a three-bit counter checks saturation.

// File: rtl/opg_pkg.sv
package opg_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic loadEarly;   // capture the cone result
    logic loadWide;    // load the wide operand register
    logic advance;     // move the early bit to the output side
  } opgStrobes_t;

  // Controlling value of the output gate: 0 for AND/NAND, 1 for OR/NOR
  function automatic logic ctrlValue(input logic [1:0] gateSel);
    return gateSel[1];
  endfunction

  // Output level produced whenever an input carries the controlling value
  function automatic logic forcedLevel(input logic [1:0] gateSel);
    return gateSel[1] ^ gateSel[0];
  endfunction

endpackage

// File: rtl/opg_ctrl.sv
module opg_ctrl
  import opg_pkg::*;
#(
  parameter logic [1:0] GATE_SEL = 2'b00,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        coneValid,
  input  logic        opValid,
  input  logic        y1Early,
  output opgStrobes_t strobes,
  output logic        resValid,
  output logic [CNT_W-1:0] holdCount
);

  localparam logic CTRL_VAL = ctrlValue(GATE_SEL);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic heldBeat;

  assign heldBeat = opValid && (y1Early == CTRL_VAL);

  always_comb begin
    strobes.loadEarly = coneValid;
    strobes.loadWide  = opValid && !heldBeat;
    strobes.advance   = opValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
    end else begin
      resValid <= opValid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCount <= '0;
    end else if (heldBeat && (holdCount != CNT_MAX)) begin
      holdCount <= holdCount + 1'b1;
    end
  end

endmodule

// File: rtl/opg_datapath.sv
module opg_datapath
  import opg_pkg::*;
#(
  parameter logic [1:0] GATE_SEL = 2'b00,
  parameter int CONE_W = 4,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W = 8,
  parameter int FIELD_RED = 0   // 0 XOR, 1 OR, 2 AND per field
) (
  input  logic                          clk,
  input  logic                          rst,
  input  opgStrobes_t                   strobes,
  input  logic [CONE_W-1:0]             coneIn,
  input  logic [NUM_FIELDS*FIELD_W-1:0] opIn,
  output logic                          y1Early,
  output logic                          y1Late,
  output logic                          resOut
);

  localparam int OP_W = NUM_FIELDS * FIELD_W;
  localparam logic IDLE_Y1 = ~ctrlValue(GATE_SEL);

  logic                  coneBit;
  logic [OP_W-1:0]       wideReg;
  logic [NUM_FIELDS-1:0] fieldBits;
  logic                  gateRaw;

  // Early cone: evaluated one cycle ahead of the wide operands
  assign coneBit = ^coneIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      y1Early <= IDLE_Y1;
    end else if (strobes.loadEarly) begin
      y1Early <= coneBit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y1Late <= IDLE_Y1;
    end else if (strobes.advance) begin
      y1Late <= y1Early;
    end
  end

  // Wide operand register: frozen while its contents are unobservable
  always_ff @(posedge clk) begin
    if (rst) begin
      wideReg <= '0;
    end else if (strobes.loadWide) begin
      wideReg <= opIn;
    end
  end

  // Wide block: one reduced bit per field
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    if (FIELD_RED == 1) begin : g_or
      assign fieldBits[k] = |wideReg[k*FIELD_W +: FIELD_W];
    end else if (FIELD_RED == 2) begin : g_and
      assign fieldBits[k] = &wideReg[k*FIELD_W +: FIELD_W];
    end else begin : g_xor
      assign fieldBits[k] = ^wideReg[k*FIELD_W +: FIELD_W];
    end
  end

  // Output gate
  if (GATE_SEL[1] == 1'b0) begin : g_andType
    assign gateRaw = y1Late & (&fieldBits);
  end else begin : g_orType
    assign gateRaw = y1Late | (|fieldBits);
  end

  assign resOut = gateRaw ^ GATE_SEL[0];

endmodule

// File: rtl/operand_gate_stage.sv
module operand_gate_stage
  import opg_pkg::*;
#(
  parameter logic [1:0] GATE_SEL = 2'b00,
  parameter int CONE_W = 4,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W = 8,
  parameter int FIELD_RED = 0,
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          coneValid,
  input  logic [CONE_W-1:0]             coneIn,
  input  logic                          opValid,
  input  logic [NUM_FIELDS*FIELD_W-1:0] opIn,
  output logic                          resOut,
  output logic                          resValid,
  output logic [CNT_W-1:0]              holdCount
);

  opgStrobes_t strobes;
  logic        y1Early;
  logic        y1Late;

  opg_ctrl #(
    .GATE_SEL (GATE_SEL),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .coneValid (coneValid),
    .opValid   (opValid),
    .y1Early   (y1Early),
    .strobes   (strobes),
    .resValid  (resValid),
    .holdCount (holdCount)
  );

  opg_datapath #(
    .GATE_SEL   (GATE_SEL),
    .CONE_W     (CONE_W),
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W),
    .FIELD_RED  (FIELD_RED)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .coneIn  (coneIn),
    .opIn    (opIn),
    .y1Early (y1Early),
    .y1Late  (y1Late),
    .resOut  (resOut)
  );

endmodule

// File: rtl/operand_gate_stage_chk.sv
module operand_gate_stage_chk
  import opg_pkg::*;
#(
  parameter logic [1:0] GATE_SEL = 2'b00,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             coneValid,
  input logic             opValid,
  input logic             y1Early,
  input logic             y1Late,
  input logic             resOut,
  input logic             resValid,
  input logic [CNT_W-1:0] holdCount
);

  localparam logic CTRL_VAL = ctrlValue(GATE_SEL);
  localparam logic FORCED   = forcedLevel(GATE_SEL);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!resValid && (holdCount == '0)));

  // R3
  beat_latency_chk: assert property (@(posedge clk) disable iff (rst)
    opValid |=> resValid);

  // R4
  forced_level_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && (y1Late == CTRL_VAL)) |-> (resOut == FORCED));

  // R5
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && (y1Early == CTRL_VAL) && (holdCount != CNT_MAX))
      |=> (holdCount == $past(holdCount) + 1'b1));

  // R6
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (holdCount == CNT_MAX) |=> (holdCount == CNT_MAX));

  // R7
  early_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !coneValid |=> $stable(y1Early));

  // R8
  idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> (!resValid && $stable(resOut) && $stable(holdCount)));

endmodule

bind operand_gate_stage operand_gate_stage_chk #(
  .GATE_SEL (GATE_SEL),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .coneValid (coneValid),
  .opValid   (opValid),
  .y1Early   (y1Early),
  .y1Late    (y1Late),
  .resOut    (resOut),
  .resValid  (resValid),
  .holdCount (holdCount)
);

// File: tb/operand_gate_stage_bench.sv
`timescale 1ns/1ps
module operand_gate_stage_bench;

  localparam int CW = 4;
  localparam int NF = 4;
  localparam int FW = 8;
  localparam int OPW = NF * FW;
  localparam int SAT_W = 3;
  localparam int SAT_MAX = (1 << SAT_W) - 1;

  typedef struct packed {
    logic            y1Known;
    logic            y1;
    logic [NF-1:0]   fb;
    logic [3:0][15:0] cnt;
    logic [15:0]     satCnt;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coneValid = 1'b0;
  logic [CW-1:0] coneIn = '0;
  logic opValid = 1'b0;
  logic [OPW-1:0] opIn = '0;

  logic [4:0] fOut;
  logic [4:0] fVal;
  logic [15:0] cnt [4];
  logic [SAT_W-1:0] satCnt;

  always #2.5 clk = ~clk;

  operand_gate_stage #(.GATE_SEL(2'b00)) u_operand_gate_stage (
    .clk(clk), .rst(rst), .coneValid(coneValid), .coneIn(coneIn),
    .opValid(opValid), .opIn(opIn), .resOut(fOut[0]), .resValid(fVal[0]),
    .holdCount(cnt[0]));
  operand_gate_stage #(.GATE_SEL(2'b01)) u_operand_gate_stage_nand (
    .clk(clk), .rst(rst), .coneValid(coneValid), .coneIn(coneIn),
    .opValid(opValid), .opIn(opIn), .resOut(fOut[1]), .resValid(fVal[1]),
    .holdCount(cnt[1]));
  operand_gate_stage #(.GATE_SEL(2'b10)) u_operand_gate_stage_or (
    .clk(clk), .rst(rst), .coneValid(coneValid), .coneIn(coneIn),
    .opValid(opValid), .opIn(opIn), .resOut(fOut[2]), .resValid(fVal[2]),
    .holdCount(cnt[2]));
  operand_gate_stage #(.GATE_SEL(2'b11)) u_operand_gate_stage_nor (
    .clk(clk), .rst(rst), .coneValid(coneValid), .coneIn(coneIn),
    .opValid(opValid), .opIn(opIn), .resOut(fOut[3]), .resValid(fVal[3]),
    .holdCount(cnt[3]));
  operand_gate_stage #(.GATE_SEL(2'b00), .CNT_W(SAT_W)) u_operand_gate_stage_sat (
    .clk(clk), .rst(rst), .coneValid(coneValid), .coneIn(coneIn),
    .opValid(opValid), .opIn(opIn), .resOut(fOut[4]), .resValid(fVal[4]),
    .holdCount(satCnt));

  int total = 0;
  int bad = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  item_t sbq[$];
  logic [4:0] prevF;

  // Bench model state
  bit modelKnown = 1'b0;
  logic modelY1 = 1'b0;
  int expCnt [4] = '{0, 0, 0, 0};
  int expSat = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Gate definition from R3/R4: sel 0 AND, 1 NAND, 2 OR, 3 NOR
  function automatic logic refGate(input int sel, input logic y1, input logic [NF-1:0] fb);
    logic r;
    r = sel[1] ? (y1 | (|fb)) : (y1 & (&fb));
    return r ^ sel[0];
  endfunction

  function automatic logic effY1(input int sel, input item_t it);
    return it.y1Known ? it.y1 : ~sel[1];
  endfunction

  // Driver: one cycle of stimulus, pushes the expected item for a wide beat
  task automatic step(input logic cv, input logic [CW-1:0] cval,
                      input logic ov, input logic [OPW-1:0] oval);
    item_t it;
    @(negedge clk);
    coneValid = cv;
    coneIn = cval;
    opValid = ov;
    opIn = oval;
    if (ov) begin
      it = '0;
      it.y1Known = modelKnown;
      it.y1 = modelY1;
      for (int k = 0; k < NF; k++) it.fb[k] = ^oval[k*FW +: FW];
      for (int g = 0; g < 4; g++) begin
        if (effY1(g, it) == g[1]) expCnt[g]++;
        it.cnt[g] = 16'(expCnt[g]);
      end
      if (effY1(0, it) == 1'b0 && expSat < SAT_MAX) expSat++;
      it.satCnt = 16'(expSat);
      sbq.push_back(it);
    end
    if (cv) begin
      modelKnown = 1'b1;
      modelY1 = ^cval;
    end
  endtask

  // Monitor: compares each produced result with the scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (fVal[0]) begin
        if (sbq.size() == 0) begin
          check("R3 unexpected result", 1, 0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          for (int g = 0; g < 4; g++) begin
            // R3 R4 result against a stage that loads every beat
            check("R3 R4 result", int'(fOut[g]), int'(refGate(g, effY1(g, it), it.fb)));
            // R5 held-beat count
            check("R5 hold count", int'(cnt[g]), int'(it.cnt[g]));
          end
          check("R3 result sat copy", int'(fOut[4]), int'(refGate(0, effY1(0, it), it.fb)));
          // R6 saturating count
          check("R6 saturated count", int'(satCnt), int'(it.satCnt));
        end
        check("R3 valid alignment", int'(fVal), 31);
      end else begin
        // R8 idle cycle: no valid, result frozen
        check("R8 valid low", int'(fVal), 0);
        check("R8 result frozen", int'(fOut), int'(prevF));
      end
    end
    prevF = fOut;
  end

  initial begin
    int holdsBefore;
    int randBeats;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid after reset", int'(fVal), 0);
    check("R1 count after reset", int'(cnt[0]) + int'(cnt[2]) + int'(satCnt), 0);
    @(negedge clk);
    rst = 1'b0;
    monOn = 1'b1;

    // R1 first beat with no cone beat: loads, not held
    step(1'b0, '0, 1'b1, 32'h0101_0101);
    step(1'b0, '0, 1'b0, '0);
    check("R1 first beat not held", int'(cnt[0]) + int'(cnt[2]), 0);

    // R2 early bit parity 1; R3 all fields odd parity
    step(1'b1, 4'b0111, 1'b0, '0);
    step(1'b0, '0, 1'b1, 32'h0107_0B01);
    // R7 reuse same early bit, one field even parity
    step(1'b0, '0, 1'b1, 32'h0103_0B01);
    // R2 early bit parity 0, controlling for AND/NAND
    step(1'b1, 4'b0110, 1'b0, '0);
    step(1'b0, '0, 1'b1, 32'h0107_0B01);
    // R8 idle cycles
    repeat (3) step(1'b0, '0, 1'b0, 32'hFFFF_FFFF);

    // R9 random pipelined stream with gaps
    holdsBefore = expCnt[0];
    randBeats = 0;
    for (int i = 0; i < 400; i++) begin
      logic cv;
      logic ov;
      cv = ($urandom % 8) != 0;
      ov = ($urandom % 8) != 0;
      if (ov) randBeats++;
      step(cv, CW'($urandom), ov, OPW'($urandom));
    end
    repeat (4) step(1'b0, '0, 1'b0, '0);
    // R9 about half of random beats held at the AND copy
    check("R9 held share low bound", int'((expCnt[0] - holdsBefore) * 10 > randBeats * 3), 1);
    check("R9 held share high bound", int'((expCnt[0] - holdsBefore) * 10 < randBeats * 7), 1);
    check("R5 count matches model", int'(cnt[0]), expCnt[0]);
    check("R3 scoreboard drained", sbq.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule